// File: doc/BRIEF.md
# Message Injection Send Unit

This block sits between a processor core and a network interface and turns word-granular send operations into a stream of network flits. Each core command carries one or two data words, a priority, and a flag saying whether the command closes the message. The first word of a message is the destination node address and the second is a handler identifier that the receiving node translates. The unit passes every word through unchanged and adds only framing: a head marker on the first word of a message, a tail marker on its last word, and the message priority.

While a message is being composed the unit holds an interrupt-mask output high, so the core cannot be diverted halfway through a message. A non-terminating send raises the mask. The handoff of the tail flit lowers it. Backpressure from the network reaches the core through the command handshake, and no word is dropped or reordered. A malformed command is reported on a one-cycle error output and has no other effect. Two kinds are malformed: a terminating send that would leave a message shorter than two words, and a send whose priority differs from that of the open message.

Top module: `msg_send_unit`

## Requirements
- R1: After reset, flit_valid, int_mask and send_err are 0 and cmd_ready is 1.
- R2: An accepted command with cmd_two=0 produces one flit carrying cmd_w0. A command with cmd_two=1 produces two flits, cmd_w0 then cmd_w1. Every flit carries the command's cmd_prio in flit_prio.
- R3: flit_head is 1 only on the first word of a message, which is the first accepted word when no message is open. flit_tail is 1 only on the last word of a command with cmd_last=1. All other flits have both markers at 0.
- R4: int_mask is 1 from the cycle after a valid command with cmd_last=0 is accepted. It returns to 0 the cycle after the tail flit is handed off, unless a non-terminating command is accepted in that same cycle.
- R5: While flit_valid=1 and flit_ready=0, the flit outputs hold steady. No word is lost, duplicated or reordered under any flit_ready pattern.
- R6: A command with cmd_last=1 that would close a message holding fewer than two words in total raises send_err for one cycle, one cycle after acceptance. It produces no flit and leaves the framing state and int_mask unchanged.
- R7: While a message is open, a command whose cmd_prio differs from the message's priority raises send_err for one cycle, one cycle after acceptance. It produces no flit and leaves the framing state and int_mask unchanged.
- R8: When no flit is pending, the first word of a valid accepted command appears on the flit port in the next cycle.
- R9: cmd_ready is 1 exactly when no flit is pending, or when one flit is pending and flit_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Core command valid |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_two | input | 1 | 1: command carries two words |
| cmd_last | input | 1 | 1: command terminates the message |
| cmd_prio | input | PRIO_W | Command priority |
| cmd_w0 | input | DATA_W | First word of the command |
| cmd_w1 | input | DATA_W | Second word (used when cmd_two=1) |
| flit_valid | output | 1 | Flit presented to the network |
| flit_ready | input | 1 | Network takes the flit |
| flit_data | output | DATA_W | Flit word |
| flit_head | output | 1 | First word of a message |
| flit_tail | output | 1 | Last word of a message |
| flit_prio | output | PRIO_W | Message priority |
| int_mask | output | 1 | Interrupts held off while a message is open |
| send_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench targets four situations. The first is a terminating single-word send from idle, which a wrong design would put on the network as a one-word message instead of rejecting. The second is a priority change in the middle of a message, which a faulty unit would splice into the open message. The third is a two-word command arriving while the previous word is still stalled; a wrong unit would overwrite the pending word or reorder it. The fourth is the interrupt mask at the tail handoff when a new message starts in the same cycle, where a wrong unit would leave interrupts enabled for the new message. Long random stretches of flit_ready at low, high and full acceptance rates are compared cycle by cycle against a queue-based model.

// File: rtl/msg_send_pkg.sv
package msg_send_pkg;
  // reason a command was rejected
  typedef enum logic [1:0] {
    REJ_NONE  = 2'd0,
    REJ_SHORT = 2'd1,
    REJ_PRIO  = 2'd2
  } rej_kind_e;

  // smallest legal message: destination plus handler identifier
  localparam int unsigned MIN_MSG_WORDS = 2;
endpackage

// File: rtl/msg_frame_ctl.sv
module msg_frame_ctl
  import msg_send_pkg::*;
#(
  parameter int unsigned PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              two,
  input  logic              last,
  input  logic [PRIO_W-1:0] prio,
  input  logic              tail_pop,
  output logic              load,
  output logic              head,
  output logic              int_mask,
  output logic              err
);
  localparam int unsigned CNT_W = $clog2(MIN_MSG_WORDS + 1);

  logic              open_q, open_n;
  logic [CNT_W-1:0]  words_q, words_n;
  logic [PRIO_W-1:0] mprio_q, mprio_n;
  logic              mask_q, mask_n;
  logic              err_q, err_n;
  rej_kind_e         rej;
  logic [CNT_W:0]    sum;

  always_comb begin
    sum = {1'b0, words_q} + (two ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
    rej = REJ_NONE;
    if (open_q && (prio != mprio_q))
      rej = REJ_PRIO;
    else if (last && (sum < (CNT_W+1)'(MIN_MSG_WORDS)))
      rej = REJ_SHORT;
  end

  assign load = acc && (rej == REJ_NONE);
  assign head = !open_q;

  always_comb begin
    open_n  = open_q;
    words_n = words_q;
    mprio_n = mprio_q;
    mask_n  = mask_q;
    err_n   = acc && (rej != REJ_NONE);
    if (load) begin
      if (last) begin
        open_n  = 1'b0;
        words_n = '0;
      end else begin
        open_n  = 1'b1;
        mprio_n = prio;
        words_n = (sum > (CNT_W+1)'(MIN_MSG_WORDS)) ? CNT_W'(MIN_MSG_WORDS)
                                                    : sum[CNT_W-1:0];
      end
    end
    if (load && !last)
      mask_n = 1'b1;
    else if (tail_pop)
      mask_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      words_q <= '0;
      mprio_q <= '0;
      mask_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q  <= err_n;
      mask_q <= mask_n;
      if (load) begin
        open_q  <= open_n;
        words_q <= words_n;
        mprio_q <= mprio_n;
      end
    end
  end

  assign int_mask = mask_q;
  assign err      = err_q;
endmodule

// File: rtl/msg_flit_stage.sv
module msg_flit_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              two,
  input  logic              last,
  input  logic              head,
  input  logic [PRIO_W-1:0] prio,
  input  logic [DATA_W-1:0] w0,
  input  logic [DATA_W-1:0] w1,
  input  logic              pop,
  output logic              valid,
  output logic              one_left,
  output logic [DATA_W-1:0] data,
  output logic              f_head,
  output logic              f_tail,
  output logic [PRIO_W-1:0] f_prio
);
  localparam int unsigned SLOTS = 2;

  logic [DATA_W-1:0] d_q [SLOTS];
  logic [DATA_W-1:0] d_n [SLOTS];
  logic [SLOTS-1:0]  h_q, h_n, t_q, t_n;
  logic [1:0]        cnt_q, cnt_n;
  logic [PRIO_W-1:0] p_q;
  logic              en;

  assign en = load || pop;

  always_comb begin
    cnt_n = cnt_q;
    h_n   = h_q;
    t_n   = t_q;
    for (int i = 0; i < SLOTS; i++) d_n[i] = d_q[i];
    if (load) begin
      d_n[0] = w0;
      d_n[1] = w1;
      h_n    = {1'b0, head};
      t_n    = {last, last && !two};
      cnt_n  = two ? 2'd2 : 2'd1;
    end else if (pop) begin
      d_n[0] = d_q[1];
      h_n    = {1'b0, h_q[1]};
      t_n    = {1'b0, t_q[1]};
      cnt_n  = cnt_q - 2'd1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q[g] <= '0;
        h_q[g] <= 1'b0;
        t_q[g] <= 1'b0;
      end else if (en) begin
        d_q[g] <= d_n[g];
        h_q[g] <= h_n[g];
        t_q[g] <= t_n[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      p_q   <= '0;
    end else begin
      if (en)   cnt_q <= cnt_n;
      if (load) p_q   <= prio;
    end
  end

  assign valid    = (cnt_q != 2'd0);
  assign one_left = (cnt_q == 2'd1);
  assign data     = d_q[0];
  assign f_head   = h_q[0];
  assign f_tail   = t_q[0];
  assign f_prio   = p_q;
endmodule

// File: rtl/msg_send_unit.sv
module msg_send_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_two,
  input  logic              cmd_last,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic [DATA_W-1:0] cmd_w0,
  input  logic [DATA_W-1:0] cmd_w1,
  output logic              flit_valid,
  input  logic              flit_ready,
  output logic [DATA_W-1:0] flit_data,
  output logic              flit_head,
  output logic              flit_tail,
  output logic [PRIO_W-1:0] flit_prio,
  output logic              int_mask,
  output logic              send_err
);
  logic acc, load, head, pop, one_left;

  assign pop       = flit_valid && flit_ready;
  assign cmd_ready = !flit_valid || (one_left && flit_ready);
  assign acc       = cmd_valid && cmd_ready;

  msg_frame_ctl #(.PRIO_W(PRIO_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .two      (cmd_two),
    .last     (cmd_last),
    .prio     (cmd_prio),
    .tail_pop (pop && flit_tail),
    .load     (load),
    .head     (head),
    .int_mask (int_mask),
    .err      (send_err)
  );

  msg_flit_stage #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .two      (cmd_two),
    .last     (cmd_last),
    .head     (head),
    .prio     (cmd_prio),
    .w0       (cmd_w0),
    .w1       (cmd_w1),
    .pop      (pop),
    .valid    (flit_valid),
    .one_left (one_left),
    .data     (flit_data),
    .f_head   (flit_head),
    .f_tail   (flit_tail),
    .f_prio   (flit_prio)
  );
endmodule

// File: rtl/msg_send_chk.sv
module msg_send_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRIO_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_last,
  input logic              flit_valid,
  input logic              flit_ready,
  input logic [DATA_W-1:0] flit_data,
  input logic              flit_head,
  input logic              flit_tail,
  input logic [PRIO_W-1:0] flit_prio,
  input logic              int_mask,
  input logic              send_err
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data) &&
      $stable(flit_head) && $stable(flit_tail) && $stable(flit_prio)));

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flit_valid |-> cmd_ready);

  // R8
  fast_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !flit_valid) |=> (flit_valid || send_err));

  // R4
  mask_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_mask) |-> $past(cmd_valid && cmd_ready && !cmd_last));

  // R4
  mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && flit_ready && flit_tail &&
     !(cmd_valid && cmd_ready && !cmd_last)) |=> !int_mask);

  // R6
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_err |-> $past(cmd_valid && cmd_ready));
endmodule

bind msg_send_unit msg_send_chk #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_last   (cmd_last),
  .flit_valid (flit_valid),
  .flit_ready (flit_ready),
  .flit_data  (flit_data),
  .flit_head  (flit_head),
  .flit_tail  (flit_tail),
  .flit_prio  (flit_prio),
  .int_mask   (int_mask),
  .send_err   (send_err)
);

// File: tb/msg_send_unit_tb.sv
module msg_send_unit_tb_top;
  localparam int DW = 16;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_ready, cmd_two, cmd_last;
  logic [PW-1:0] cmd_prio;
  logic [DW-1:0] cmd_w0, cmd_w1;
  logic          flit_valid, flit_ready, flit_head, flit_tail;
  logic [DW-1:0] flit_data;
  logic [PW-1:0] flit_prio;
  logic          int_mask, send_err;

  always #2.5 clk = ~clk;

  msg_send_unit #(.DATA_W(DW), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_two(cmd_two), .cmd_last(cmd_last), .cmd_prio(cmd_prio),
    .cmd_w0(cmd_w0), .cmd_w1(cmd_w1), .flit_valid(flit_valid),
    .flit_ready(flit_ready), .flit_data(flit_data), .flit_head(flit_head),
    .flit_tail(flit_tail), .flit_prio(flit_prio), .int_mask(int_mask),
    .send_err(send_err)
  );

  typedef struct packed {
    logic [DW-1:0] d;
    logic          h;
    logic          t;
    logic [PW-1:0] p;
  } flit_t;

  // behavioural reference
  flit_t         q[$];
  bit            m_open, m_mask, m_err;
  int            m_words, m_errkind, rdy_mode;
  logic [PW-1:0] m_prio;
  int            total = 0, bad = 0, cycles = 0;

  function automatic bit exp_ready();
    return (q.size() == 0) || (q.size() == 1 && flit_ready);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_open = 0; m_mask = 0; m_err = 0; m_words = 0;
      m_prio = '0; m_errkind = 0;
    end else begin
      bit acc, popt, nonterm_ok;
      int n, kind;
      flit_t f;
      acc  = cmd_valid && exp_ready();
      popt = 0;
      if (q.size() > 0 && flit_ready) begin
        f = q.pop_front();
        popt = f.t;
      end
      n = cmd_two ? 2 : 1;
      kind = 0;
      if (acc) begin
        if (m_open && cmd_prio != m_prio) kind = 7;
        else if (cmd_last && m_words + n < 2) kind = 6;
      end
      m_err = acc && kind != 0;
      m_errkind = kind;
      nonterm_ok = 0;
      if (acc && kind == 0) begin
        f.d = cmd_w0; f.h = !m_open; f.p = cmd_prio; f.t = cmd_last && !cmd_two;
        q.push_back(f);
        if (cmd_two) begin
          f.d = cmd_w1; f.h = 0; f.t = cmd_last;
          q.push_back(f);
        end
        if (cmd_last) begin m_open = 0; m_words = 0; end
        else begin m_open = 1; m_words += n; m_prio = cmd_prio; nonterm_ok = 1; end
      end
      if (nonterm_ok) m_mask = 1;
      else if (popt) m_mask = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cmd_ready == exp_ready(), "R9", "cmd_ready", cmd_ready, exp_ready());
    chk(flit_valid == (q.size() > 0), "R5", "flit_valid", flit_valid, q.size() > 0);
    if (q.size() > 0 && flit_valid) begin
      chk(flit_data == q[0].d, "R2", "flit_data", flit_data, q[0].d);
      chk(flit_prio == q[0].p, "R2", "flit_prio", flit_prio, q[0].p);
      chk(flit_head == q[0].h, "R3", "flit_head", flit_head, q[0].h);
      chk(flit_tail == q[0].t, "R3", "flit_tail", flit_tail, q[0].t);
    end
    chk(int_mask == m_mask, "R4", "int_mask", int_mask, m_mask);
    chk(send_err == m_err, (m_errkind == 7) ? "R7" : "R6", "send_err",
        send_err, m_err);
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    compare();
    case (rdy_mode)
      0: flit_ready = 1'b1;
      1: flit_ready = ($urandom % 4) == 0;
      default: flit_ready = ($urandom % 2) == 0;
    endcase
    #1;
  endtask

  task automatic send(input bit two, input bit last, input logic [PW-1:0] p,
                      input logic [DW-1:0] a, input logic [DW-1:0] b);
    bit was;
    cmd_valid = 1; cmd_two = two; cmd_last = last; cmd_prio = p;
    cmd_w0 = a; cmd_w1 = b;
    do begin
      was = cmd_ready;
      step();
    end while (!was);
    cmd_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) step();
  endtask

  initial begin
    #(5 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_two = 0; cmd_last = 0; cmd_prio = '0;
    cmd_w0 = '0; cmd_w1 = '0; flit_ready = 0; rdy_mode = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmd_ready == 1, "R1", "cmd_ready", cmd_ready, 1);
    chk(flit_valid == 0, "R1", "flit_valid", flit_valid, 0);
    chk(int_mask == 0, "R1", "int_mask", int_mask, 0);
    chk(send_err == 0, "R1", "send_err", send_err, 0);
    rst_n = 1;
    step();

    // R6: terminating single word from idle rejected
    send(0, 1, 2'd1, 16'hDEAD, 16'h0);
    step();
    chk(flit_valid == 0, "R6", "no flit after short msg", flit_valid, 0);
    // R2 R3: two-word terminating message from idle (head+tail)
    send(1, 1, 2'd2, 16'h0011, 16'h00AA);
    drain();
    // R4: single-word sends building a message
    send(0, 0, 2'd3, 16'h0101, 16'h0);
    step();
    chk(int_mask == 1, "R4", "mask after open", int_mask, 1);
    // R7: priority change mid-message rejected
    send(0, 0, 2'd0, 16'hBAD0, 16'h0);
    send(1, 0, 2'd3, 16'h0202, 16'h0303);
    send(0, 1, 2'd3, 16'h0404, 16'h0);
    drain();
    chk(int_mask == 0, "R4", "mask after tail", int_mask, 0);
    // R6: one-word open then terminating single is legal (2 words)
    send(0, 0, 2'd1, 16'h0505, 16'h0);
    send(0, 1, 2'd1, 16'h0606, 16'h0);
    // R4: tail handoff coinciding with a new opening send
    send(1, 0, 2'd2, 16'h0707, 16'h0808);
    send(0, 1, 2'd2, 16'h0909, 16'h0);
    drain();

    // R5 R8 R9: random traffic under three backpressure modes
    for (int m = 0; m < 3; m++) begin
      rdy_mode = m;
      for (int k = 0; k < 600; k++) begin
        bit two, last;
        logic [PW-1:0] p;
        two  = $urandom % 2;
        last = ($urandom % 3) == 0;
        p    = (($urandom % 8) == 0) ? PW'($urandom) : PW'(m);
        send(two, last, p, DW'($urandom), DW'($urandom));
        if (($urandom % 5) == 0) step();
      end
      send(0, 0, PW'(m), 16'h1234, 16'h0);
      send(0, 1, PW'(m), 16'h5678, 16'h0);
      drain();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule